// File: doc/BRIEF.md
# Interleaved Recirculating Frame Store

This block keeps complete raster pictures in circulating serial loops. Each picture is split across two loops. Even-numbered picture bits live in one loop and odd-numbered bits in the other. Each accepted shift strobe takes one bit from alternate loops, so the merged output is one video bit stream in picture order. Three independent pictures are held side by side in banks, and a 2-bit index picks the bank that a strobe acts on.

The loops move only when an external timing block raises `shift_en`. Between strobes, every stored bit stays where it is for as long as needed. A strobe either writes the bit leaving a loop back into that loop, or, when loading, replaces it with a new serial bit.

The registered video output has a frequency-mark overlay. While a mark is active, a lit memory bit is shown dark, so the mark appears as a dark line across the picture. A full-size picture uses `LOOP_LEN` = 18432. The default is kept small so that the block elaborates quickly.

A two-state phase machine (`PH_EVEN`, `PH_ODD`) selects the loop that the next accepted strobe serves:
- `PH_EVEN` to `PH_ODD` on an accepted strobe.
- `PH_ODD` to `PH_EVEN` on an accepted strobe.
- Each state stays in place without one.
- Reset enters `PH_EVEN`.

Top module: `vid_store`

## Requirements
- R1: A synchronous active-high `rst` sets `video_out` to 0, puts the phase machine in `PH_EVEN`, and clears every loop bit in every bank to 0. A readback of any bank after reset gives all zeros.
- R2: When `shift_en` is low, no loop moves, the phase holds and `video_out` keeps its value. Stored pictures survive any idle length.
- R3: Accepted strobes alternate between the even loop and the odd loop, starting with the even loop after reset. Picture bit k (counted from 0) is held in the even loop when k is even.
- R4: When `load_en` is high on an accepted strobe, `load_bit` replaces the bit leaving the served loop. After 2*LOOP_LEN loading strobes, the next 2*LOOP_LEN strobes to that bank return the loaded bits in the order they were loaded.
- R5: When `load_en` is low, the leaving bit is written back, so a bank returns the same picture every 2*LOOP_LEN strobes, indefinitely.
- R6: `video_out` changes only on the clock edge that samples an accepted strobe. It then takes the bit leaving the served loop, ANDed with the inverse of `mark_en`.
- R7: An accepted strobe with `mark_en` high drives `video_out` to 0 on that edge, including when the stored bit is 1.
- R8: `bank_sel` values 0, 1 and 2 select three independent pictures. A strobe moves only the selected bank.
- R9: A strobe with `bank_sel` = 3 is ignored: no bank moves, the phase does not toggle and `video_out` holds.
- R10: During a loading strobe, `video_out` shows the old bit leaving the loop, not the incoming `load_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Shift strobe from the timing block |
| bank_sel | input | 2 | Bank index: 0 to 2 select a picture, 3 selects none |
| load_en | input | 1 | Replace the leaving bit with `load_bit` |
| load_bit | input | 1 | Incoming serial picture bit |
| mark_en | input | 1 | Frequency-mark position active |
| video_out | output | 1 | Registered video bit |

## Verification
A wrong phase shows at the ports as a readback that is shifted by one bit, or as a picture whose even and odd bits are swapped. This appears on the first readback pass after the fault. A loop that drops or corrupts a bit shows up as a mismatch at that bit's position in the next pass through the bank, no later than 2*LOOP_LEN strobes. A strobe that leaks into a bank it should not touch leaves that bank's picture out of alignment, which the next readback of that bank exposes. A broken hold path changes `video_out` during idle cycles, which shows immediately.

// File: rtl/vid_store_pkg.sv
package vid_store_pkg;
    typedef enum logic {
        PH_EVEN = 1'b0,
        PH_ODD  = 1'b1
    } phase_t;
endpackage

// File: rtl/vs_loop.sv
// One circulating serial loop: bit 0 is the head leaving the loop,
// the tail entry is either the head written back or a fresh bit.
module vs_loop #(
    parameter int DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic load,
    input  logic din,
    output logic head
);
    logic [DEPTH-1:0] bits_q;
    logic             entry;

    assign entry = load ? din : bits_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (step) begin
            bits_q <= {entry, bits_q[DEPTH-1:1]};
        end
    end

    assign head = bits_q[0];
endmodule

// File: rtl/vs_bank.sv
// One picture: an even loop and an odd loop, served by phase.
module vs_bank
    import vid_store_pkg::*;
#(
    parameter int LOOP_LEN = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       step,
    input  phase_t     phase,
    input  logic       load,
    input  logic       din,
    output logic [1:0] heads
);
    localparam int NUM_LOOPS = 2;

    for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
        localparam phase_t MY_PHASE = (g == 1) ? PH_ODD : PH_EVEN;
        vs_loop #(.DEPTH(LOOP_LEN)) u_loop (
            .clk  (clk),
            .rst  (rst),
            .step (step && (phase == MY_PHASE)),
            .load (load),
            .din  (din),
            .head (heads[g])
        );
    end
endmodule

// File: rtl/vid_store.sv
module vid_store
    import vid_store_pkg::*;
#(
    parameter int LOOP_LEN  = 16,
    parameter int NUM_BANKS = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       shift_en,
    input  logic [1:0] bank_sel,
    input  logic       load_en,
    input  logic       load_bit,
    input  logic       mark_en,
    output logic       video_out
);
    localparam int BANK_W = 2;

    phase_t                        phase_q, phase_d;
    logic                          accept;
    logic                          cur_head;
    logic                          video_q;
    logic [NUM_BANKS-1:0][1:0]     heads;

    assign accept = shift_en && (int'(bank_sel) < NUM_BANKS);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_EVEN;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Next-state logic
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_EVEN: if (accept) phase_d = PH_ODD;
            PH_ODD:  if (accept) phase_d = PH_EVEN;
        endcase
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        vs_bank #(.LOOP_LEN(LOOP_LEN)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .step  (accept && (bank_sel == BANK_W'(b))),
            .phase (phase_q),
            .load  (load_en),
            .din   (load_bit),
            .heads (heads[b])
        );
    end

    always_comb begin
        cur_head = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank_sel == BANK_W'(i)) begin
                cur_head = (phase_q == PH_ODD) ? heads[i][1] : heads[i][0];
            end
        end
    end

    // Output process
    always_ff @(posedge clk) begin
        if (rst) begin
            video_q <= 1'b0;
        end else if (accept) begin
            video_q <= cur_head & ~mark_en;
        end
    end

    assign video_out = video_q;
endmodule

// File: rtl/vid_store_chk.sv
module vid_store_chk
    import vid_store_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       shift_en,
    input logic [1:0] bank_sel,
    input logic       mark_en,
    input logic       video_out,
    input phase_t     phase_q
);
    a_r1_reset_dark: assert property (@(posedge clk)
        rst |=> !video_out);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(video_out) && $stable(phase_q));

    a_r3_phase_flip: assert property (@(posedge clk) disable iff (rst)
        (shift_en && bank_sel != 2'd3) |=> phase_q != $past(phase_q));

    a_r7_mark_dark: assert property (@(posedge clk) disable iff (rst)
        (shift_en && bank_sel != 2'd3 && mark_en) |=> !video_out);

    a_r9_none_ignored: assert property (@(posedge clk) disable iff (rst)
        (shift_en && bank_sel == 2'd3) |=> $stable(video_out) && $stable(phase_q));
endmodule

bind vid_store vid_store_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (shift_en),
    .bank_sel  (bank_sel),
    .mark_en   (mark_en),
    .video_out (video_out),
    .phase_q   (phase_q)
);

// File: tb/sim_vid_store.sv
module sim_vid_store;
    localparam int LEN = 16;
    localparam int PIX = 2 * LEN;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       shift_en = 1'b0;
    logic [1:0] bank_sel = 2'd0;
    logic       load_en = 1'b0;
    logic       load_bit = 1'b0;
    logic       mark_en = 1'b0;
    logic       video_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic model [3][PIX];
    int   idx [3];
    logic last_vid;

    // bank, picture
    localparam logic [33:0] TBL [3] = '{
        {2'd0, 32'hA5C3_0F96},
        {2'd1, 32'h1234_FEDC},
        {2'd2, 32'hFFFF_0001}
    };

    always #10 clk = ~clk;

    vid_store #(.LOOP_LEN(LEN), .NUM_BANKS(3)) u0 (
        .clk(clk), .rst(rst), .shift_en(shift_en), .bank_sel(bank_sel),
        .load_en(load_en), .load_bit(load_bit), .mark_en(mark_en),
        .video_out(video_out)
    );

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic model_clear();
        for (int b = 0; b < 3; b++) begin
            idx[b] = 0;
            for (int i = 0; i < PIX; i++) model[b][i] = 1'b0;
        end
        last_vid = 1'b0;
    endtask

    // One strobe: drive at negedge, edge captures, sample at next negedge.
    task automatic strobe(input int b, input logic ld, input logic bv,
                          input logic mk, input string tag);
        logic e;
        @(negedge clk);
        shift_en = 1'b1; bank_sel = 2'(b); load_en = ld; load_bit = bv; mark_en = mk;
        @(negedge clk);
        shift_en = 1'b0; load_en = 1'b0; mark_en = 1'b0;
        if (b < 3) begin
            e = model[b][idx[b]] & ~mk;
            if (ld) model[b][idx[b]] = bv;
            idx[b] = (idx[b] + 1) % PIX;
            last_vid = e;
        end else begin
            e = last_vid;
        end
        check(video_out, e, tag);
    endtask

    task automatic read_pass(input int b, input string tag);
        for (int i = 0; i < PIX; i++) strobe(b, 1'b0, 1'b0, 1'b0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    initial begin
        model_clear();
        do_reset();
        check(video_out, 1'b0, "R1 video after reset");
        read_pass(0, "R1 cleared bank0");
        read_pass(2, "R1 cleared bank2");

        // Table walk: load each bank (R4, R10 on old bits) then read back twice (R4, R5, R3)
        for (int t = 0; t < 3; t++) begin
            int b;
            b = int'(TBL[t][33:32]);
            for (int i = 0; i < PIX; i++)
                strobe(b, 1'b1, TBL[t][i], 1'b0, "R10 old bit during load");
            read_pass(b, "R4 loaded readback");
            read_pass(b, "R5 recirculation");
        end

        // R8: banks independent after all loads
        read_pass(0, "R8 bank0 independent");
        read_pass(1, "R8 bank1 independent");

        // R7: marks over a mostly lit picture
        for (int i = 0; i < PIX; i++)
            strobe(2, 1'b0, 1'b0, (i % 3) == 0, "R7 mark dark / R6 value");

        // R2: long idle, output and contents hold
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (c % 50 == 0) check(video_out, last_vid, "R2 idle hold");
        end
        read_pass(1, "R2 contents after idle");

        // R9: strobes with index 3 ignored
        strobe(0, 1'b0, 1'b0, 1'b0, "R6 one strobe bank0");
        for (int i = 0; i < 5; i++) strobe(3, 1'b1, 1'b1, 1'b0, "R9 index 3 ignored");
        for (int i = 1; i < PIX; i++) strobe(0, 1'b0, 1'b0, 1'b0, "R9 bank0 aligned");
        read_pass(0, "R9 bank0 intact");

        // R3/R1: odd number of strobes, then reset must restore even phase
        for (int i = 0; i < 7; i++) strobe(1, 1'b1, 1'b1, 1'b0, "R10 partial load");
        do_reset();
        check(video_out, 1'b0, "R1 video after mid reset");
        read_pass(1, "R1 bank1 cleared");
        for (int i = 0; i < PIX; i++)
            strobe(1, 1'b1, (i % 4) == 1, 1'b0, "R3 load after reset");
        read_pass(1, "R3 phase restart even");

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule